// File: doc/BRIEF.md
# Write-Protection Command Sequence Guard

This block sits beside the write path of a byte-wide non-volatile memory and watches every byte write cycle, given as an address and a data byte. It recognises two fixed command sequences written to magic addresses. One sequence unlocks a protected write, and the same sequence switches protection on. The other sequence switches protection off. From these it keeps a single protection mode bit and decides, for each write, whether that byte may go on to the array.

While protection is off, ordinary writes pass. While protection is on, a write passes only inside a page that a three-write unlock prefix opened. The page ends when the write controller signals that it has committed the page. The command bytes are never passed to the array. A prefix with no data write after it leaves the mode as it was. Each write gets one registered verdict, and the verdict reports the protection mode as updated by that write.

Top module: `sdp_guard`

## Requirements
- R1: After reset, prot_on is 0 and res_valid is 0.
- R2: With protection off, a write that is not part of a command sequence produces res_valid=1 and res_allow=1 one clock after the write is presented.
- R3: The unlock prefix is three writes: address 5555h with data AAh, then 2AAAh with data 55h, then 5555h with data A0h. Each prefix write gets res_allow=0. If the page is committed before any data write follows, the prefix leaves prot_on unchanged.
- R4: The first data write after an unlock prefix is allowed (res_allow=1) and sets prot_on to 1 in its own verdict.
- R5: While prot_on is 1, a data write that no unlock prefix precedes gets res_allow=0.
- R6: After an unlock prefix, every data write up to the next page_commit is allowed. The first data write after page_commit with no new prefix is dropped.
- R7: The six writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/20h clear prot_on. The clear is visible in the verdict of the sixth write, and none of the six writes is allowed.
- R8: Address matching uses only address bits 14..0. So AAAAh matches the 2AAAh step, and 1D555h matches the 5555h step.
- R9: A write that breaks a partial sequence aborts it. That write is judged against the current mode: it is allowed if protection is off and dropped if protection is on. A breaking write of 5555h/AAh starts a new sequence instead.
- R10: prot_on changes only in a cycle where res_valid is 1. A page_commit with no open unlock has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A byte write cycle is presented this clock |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| page_commit | input | 1 | The write controller has committed the current page |
| res_valid | output | 1 | Verdict for the write of the previous clock is present |
| res_allow | output | 1 | That write may reach the array |
| prot_on | output | 1 | Current protection mode |

## Verification
Every verdict, and the protection mode that goes with it, is registered once. Both appear exactly one clock after the write is presented. The bench drives each write on a falling edge and pushes the expected verdict and mode into a queue. A monitor pops that entry on the next falling edge whenever res_valid is high. An unexpected or missing verdict is caught this way, and so is one that arrives a clock late. The effect of page_commit is checked one clock after the commit, through prot_on and through the verdict of the next write.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int BYTE_W  = 8;
  localparam int MATCH_W = 15;

  localparam logic [MATCH_W-1:0] ADR_STEP_A = 15'h5555;
  localparam logic [MATCH_W-1:0] ADR_STEP_B = 15'h2AAA;

  localparam logic [BYTE_W-1:0] KEY_LEAD   = 8'hAA;
  localparam logic [BYTE_W-1:0] KEY_SECOND = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_OPEN   = 8'hA0;
  localparam logic [BYTE_W-1:0] KEY_ERASE  = 8'h80;
  localparam logic [BYTE_W-1:0] KEY_OFF    = 8'h20;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_SECOND,
    SQ_OPEN,
    SQ_OFF3,
    SQ_OFF4,
    SQ_OFF5
  } seq_state_t;

  typedef struct packed {
    logic lead;
    logic second;
    logic open;
    logic erase;
    logic off;
  } key_hits_t;
endpackage

// File: rtl/sdp_key_match.sv
module sdp_key_match
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] data,
  output key_hits_t         hits
);
  logic [MATCH_W-1:0] low_addr;
  logic               at_a;
  logic               at_b;

  assign low_addr = addr[MATCH_W-1:0];
  assign at_a     = (low_addr == ADR_STEP_A);
  assign at_b     = (low_addr == ADR_STEP_B);

  always_comb begin
    hits.lead   = at_a && (data == KEY_LEAD);
    hits.second = at_b && (data == KEY_SECOND);
    hits.open   = at_a && (data == KEY_OPEN);
    hits.erase  = at_a && (data == KEY_ERASE);
    hits.off    = at_a && (data == KEY_OFF);
  end
endmodule

// File: rtl/sdp_seq_next.sv
module sdp_seq_next
  import sdp_pkg::*;
(
  input  seq_state_t cur_st,
  input  logic       cur_prot,
  input  logic       wr_valid,
  input  logic       page_commit,
  input  key_hits_t  hits,
  output seq_state_t nxt_st,
  output logic       nxt_prot,
  output logic       allow
);
  always_comb begin
    nxt_st   = cur_st;
    nxt_prot = cur_prot;
    allow    = 1'b0;
    if (wr_valid) begin
      unique case (cur_st)
        SQ_OPEN: begin
          allow    = 1'b1;
          nxt_prot = 1'b1;
        end
        SQ_LEAD: begin
          if (hits.second)    nxt_st = SQ_SECOND;
          else if (hits.lead) nxt_st = SQ_LEAD;
          else begin nxt_st = SQ_IDLE; allow = !cur_prot; end
        end
        SQ_SECOND: begin
          if (hits.open)       nxt_st = SQ_OPEN;
          else if (hits.erase) nxt_st = SQ_OFF3;
          else if (hits.lead)  nxt_st = SQ_LEAD;
          else begin nxt_st = SQ_IDLE; allow = !cur_prot; end
        end
        SQ_OFF3: begin
          if (hits.lead) nxt_st = SQ_OFF4;
          else begin nxt_st = SQ_IDLE; allow = !cur_prot; end
        end
        SQ_OFF4: begin
          if (hits.second)    nxt_st = SQ_OFF5;
          else if (hits.lead) nxt_st = SQ_LEAD;
          else begin nxt_st = SQ_IDLE; allow = !cur_prot; end
        end
        SQ_OFF5: begin
          if (hits.off) begin
            nxt_st   = SQ_IDLE;
            nxt_prot = 1'b0;
          end
          else if (hits.lead) nxt_st = SQ_LEAD;
          else begin nxt_st = SQ_IDLE; allow = !cur_prot; end
        end
        default: begin
          if (hits.lead) nxt_st = SQ_LEAD;
          else           allow  = !cur_prot;
        end
      endcase
    end
    if (page_commit && cur_st == SQ_OPEN) nxt_st = SQ_IDLE;
  end
endmodule

// File: rtl/sdp_guard.sv
module sdp_guard
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              page_commit,
  output logic              res_valid,
  output logic              res_allow,
  output logic              prot_on
);
  key_hits_t  hits;
  seq_state_t st_q, st_d;
  logic       prot_d, allow_d;

  sdp_key_match #(.ADDR_W(ADDR_W)) u_match (
    .addr (wr_addr),
    .data (wr_data),
    .hits (hits)
  );

  sdp_seq_next u_next (
    .cur_st      (st_q),
    .cur_prot    (prot_on),
    .wr_valid    (wr_valid),
    .page_commit (page_commit),
    .hits        (hits),
    .nxt_st      (st_d),
    .nxt_prot    (prot_d),
    .allow       (allow_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      prot_on   <= 1'b0;
      res_valid <= 1'b0;
      res_allow <= 1'b0;
    end else begin
      st_q      <= st_d;
      prot_on   <= prot_d;
      res_valid <= wr_valid;
      res_allow <= allow_d;
    end
  end
endmodule

// File: rtl/sdp_guard_chk.sv
module sdp_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic res_valid,
  input logic res_allow,
  input logic prot_on
);
  // R2
  verdict_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_allow |-> res_valid);
  // R4
  prot_rise_on_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> (res_valid && res_allow));
  // R7
  prot_fall_on_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> (res_valid && !res_allow));
  // R10
  prot_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(prot_on));
endmodule

bind sdp_guard sdp_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .res_allow (res_allow),
  .prot_on   (prot_on)
);

// File: tb/sim_sdp_guard.sv
`timescale 1ns/1ps
module sim_sdp_guard;
  typedef struct {
    logic  allow;
    logic  prot;
    string req;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        wr_valid;
  logic [16:0] wr_addr;
  logic [7:0]  wr_data;
  logic        page_commit;
  logic        res_valid, res_allow, prot_on;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  exp_t sb[$];

  sdp_guard u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .page_commit(page_commit), .res_valid(res_valid),
    .res_allow(res_allow), .prot_on(prot_on)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Driver: one write per clock, expected verdict pushed to the scoreboard
  task automatic wr(logic [16:0] a, logic [7:0] d, logic ea, logic ep, string req);
    exp_t e;
    e.allow = ea; e.prot = ep; e.req = req;
    sb.push_back(e);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic commit(logic ep, string req);
    page_commit = 1'b1;
    @(negedge clk);
    page_commit = 1'b0;
    check(req, prot_on, ep, "prot_on after commit");
  endtask

  // Monitor: verdict due one clock after the write
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected verdict: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, res_allow, e.allow, "res_allow");
        check(e.req, prot_on,   e.prot,  "prot_on");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; page_commit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", prot_on, 1'b0, "prot_on after reset");
    check("R1", res_valid, 1'b0, "res_valid after reset");

    wr(17'h00100, 8'h11, 1, 0, "R2");
    wr(17'h1FFFF, 8'h22, 1, 0, "R2");

    // Prefix alone, then commit: mode unchanged
    wr(17'h05555, 8'hAA, 0, 0, "R3");
    wr(17'h02AAA, 8'h55, 0, 0, "R3");
    wr(17'h05555, 8'hA0, 0, 0, "R3");
    @(negedge clk);
    commit(0, "R3");
    wr(17'h00200, 8'h33, 1, 0, "R3");

    // Prefix with the high alias of the second step, then a page
    wr(17'h05555, 8'hAA, 0, 0, "R8");
    wr(17'h0AAAA, 8'h55, 0, 0, "R8");
    wr(17'h05555, 8'hA0, 0, 0, "R4");
    wr(17'h00300, 8'h44, 1, 1, "R4");
    wr(17'h00301, 8'h45, 1, 1, "R6");
    wr(17'h05555, 8'hAA, 1, 1, "R6");
    @(negedge clk);
    commit(1, "R6");
    wr(17'h00302, 8'h46, 0, 1, "R6");
    wr(17'h00400, 8'h01, 0, 1, "R5");

    // Broken sequence under protection
    wr(17'h05555, 8'hAA, 0, 1, "R9");
    wr(17'h00500, 8'h07, 0, 1, "R9");
    wr(17'h00010, 8'h09, 0, 1, "R5");
    commit(1, "R10");

    // Disable sequence, first step via an upper-bit alias
    wr(17'h1D555, 8'hAA, 0, 1, "R8");
    wr(17'h02AAA, 8'h55, 0, 1, "R7");
    wr(17'h05555, 8'h80, 0, 1, "R7");
    wr(17'h05555, 8'hAA, 0, 1, "R7");
    wr(17'h02AAA, 8'h55, 0, 1, "R7");
    wr(17'h05555, 8'h20, 0, 0, "R7");
    wr(17'h00600, 8'h05, 1, 0, "R7");

    // Broken sequence without protection; restart on a lead byte
    wr(17'h05555, 8'hAA, 0, 0, "R9");
    wr(17'h00700, 8'h03, 1, 0, "R9");
    wr(17'h05555, 8'hAA, 0, 0, "R9");
    wr(17'h02AAA, 8'h55, 0, 0, "R9");
    wr(17'h05555, 8'hAA, 0, 0, "R9");
    wr(17'h00701, 8'h04, 1, 0, "R9");

    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2 missing verdicts: actual %0d expected 0", sb.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule